// File: doc/BRIEF.md
# Indexed Memory-Attribute Register Bank

This block holds a small bank of 64-bit registers. Each register describes attributes of one physical memory region: a valid flag, a bound on the address, and two attribute bits. Software reaches a register by first loading a separate index register and then reading or writing the register that the index selects. Writes arrive as 32-bit halves. A low-half write replaces the whole entry. A high-half write merges into the upper half and keeps the lower half.

Each data write passes through a mask of writable bits. The mask depends on the configured physical address width, and every bit outside it reads as zero. The index register accepts only values that name an implemented entry. Writing the all-ones index value is a probe: it loads the largest implemented index. Reads are combinational from the current index, in three forms: a sign-extended low half, a raw high half, and the full 64 bits.

Top module: `attr_bank`

## Requirements
- R1: After reset every entry is zero and the index is zero.
- R2: A low-half write sets the selected entry to the 32-bit data, zero-extended to 64 bits and ANDed with the writable mask, so bit 63 is cleared.
- R3: A high-half write sets bits 63:32 of the selected entry to the data ANDed with mask bits 63:32 and leaves bits 31:0 unchanged.
- R4: The writable mask has bit 63, bits 1:0, and bits 12 up to PA_WIDTH-5 set. With the default PA_WIDTH of 36 this is 64'h8000_0000_FFFF_F003. No other bit can ever read as one.
- R5: An index write whose bits 5:0 equal 6'h3F sets the index to NUM_ENTRIES-1.
- R6: An index write whose bits 5:0 are below NUM_ENTRIES stores bits 5:0. Bits 31:6 of the written word have no effect.
- R7: An index write whose bits 5:0 lie from NUM_ENTRIES to 6'h3E leaves the index unchanged.
- R8: rd_lo_o is bits 31:0 of the selected entry, sign-extended to 64 bits.
- R9: rd_hi_o is bits 63:32 of the selected entry, and rd_full_o is the whole 64-bit entry.
- R10: idx_o is the current index, zero-extended to 32 bits.
- R11: A data write changes only the entry that the index selects.
- R12: Writes take effect at the rising clock edge. Before that edge the read outputs still show the old contents and the old index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_lo_i | input | 1 | Low-half data write strobe |
| wr_hi_i | input | 1 | High-half data write strobe |
| wr_idx_i | input | 1 | Index register write strobe |
| wdata_i | input | 32 | Write data for all three strobes |
| rd_lo_o | output | 64 | Sign-extended low half of the selected entry |
| rd_hi_o | output | 32 | High half of the selected entry |
| rd_full_o | output | 64 | Full selected entry |
| idx_o | output | 32 | Current index, zero-extended |

## Verification
Within one cycle a combinational read of the selected entry can coincide with a write to that same entry, or with a write that moves the index. The bench raises a write strobe at the falling edge and samples the read outputs before the next rising edge, where they must still show the old entry. It samples them again after that edge, where they must show the merged or re-selected value. Merges are checked by writing the two halves in both orders, and every result is compared against a model of the mask and the index held in the bench.

// File: rtl/attr_bank_pkg.sv
package attr_bank_pkg;
  localparam int unsigned IDX_W = 6;
  localparam int unsigned DW    = 64;
  localparam logic [IDX_W-1:0] IDX_PROBE = '1;

  // writable bits: valid flag, attribute bits, bound field from (PA mask >> 4) above bit 11
  function automatic logic [DW-1:0] wr_mask(input int unsigned pa_w);
    logic [DW-1:0] m;
    for (int b = 0; b < DW; b++) begin
      m[b] = (b >= 12) && ((b + 4) < pa_w);
    end
    m[DW-1] = 1'b1;
    m[1:0]  = 2'b11;
    return m;
  endfunction
endpackage

// File: rtl/attr_bank_index.sv
module attr_bank_index
  import attr_bank_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] field_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (we_i) begin
      if (field_i == IDX_PROBE)             idx_d = MAX_IDX;
      else if (32'(field_i) < NUM_ENTRIES)  idx_d = field_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/attr_bank_store.sv
module attr_bank_store
  import attr_bank_pkg::*;
#(
  parameter int unsigned   NUM_ENTRIES = 16,
  parameter logic [DW-1:0] MASK        = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [DW-1:0]    entry_o
);
  logic [DW-1:0] ent_q [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = (idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[e] <= '0;
      end else if (sel && wr_lo_i) begin
        ent_q[e] <= {32'h0, wdata_i} & MASK;
      end else if (sel && wr_hi_i) begin
        ent_q[e] <= {wdata_i & MASK[63:32], ent_q[e][31:0]};
      end
    end
  end

  always_comb begin
    entry_o = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (idx_i == IDX_W'(e)) entry_o = ent_q[e];
    end
  end
endmodule

// File: rtl/attr_bank_rdfmt.sv
module attr_bank_rdfmt
  import attr_bank_pkg::*;
(
  input  logic [DW-1:0] entry_i,
  output logic [DW-1:0] lo_o,
  output logic [31:0]   hi_o,
  output logic [DW-1:0] full_o
);
  assign lo_o   = {{32{entry_i[31]}}, entry_i[31:0]};
  assign hi_o   = entry_i[63:32];
  assign full_o = entry_i;
endmodule

// File: rtl/attr_bank.sv
module attr_bank
  import attr_bank_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned PA_WIDTH    = 36
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic        wr_idx_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] rd_lo_o,
  output logic [31:0] rd_hi_o,
  output logic [63:0] rd_full_o,
  output logic [31:0] idx_o
);
  localparam logic [DW-1:0] MASK = wr_mask(PA_WIDTH);

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    entry;

  attr_bank_index #(.NUM_ENTRIES(NUM_ENTRIES)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_idx_i),
    .field_i (wdata_i[IDX_W-1:0]),
    .idx_o   (idx)
  );

  attr_bank_store #(.NUM_ENTRIES(NUM_ENTRIES), .MASK(MASK)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_lo_i),
    .wr_hi_i (wr_hi_i),
    .wdata_i (wdata_i),
    .idx_i   (idx),
    .entry_o (entry)
  );

  attr_bank_rdfmt u_rdfmt (
    .entry_i (entry),
    .lo_o    (rd_lo_o),
    .hi_o    (rd_hi_o),
    .full_o  (rd_full_o)
  );

  assign idx_o = 32'(idx);
endmodule

// File: rtl/attr_bank_chk.sv
module attr_bank_chk
  import attr_bank_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned PA_WIDTH    = 36
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_lo_i,
  input logic        wr_hi_i,
  input logic        wr_idx_i,
  input logic [31:0] wdata_i,
  input logic [63:0] rd_lo_o,
  input logic [31:0] rd_hi_o,
  input logic [63:0] rd_full_o,
  input logic [31:0] idx_o
);
  localparam logic [63:0] MASK = wr_mask(PA_WIDTH);

  logic probe, oor;
  assign probe = wr_idx_i && (wdata_i[5:0] == IDX_PROBE);
  assign oor   = wr_idx_i && (wdata_i[5:0] != IDX_PROBE) && (32'(wdata_i[5:0]) >= NUM_ENTRIES);

  p_lo_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> rd_full_o == ({32'h0, $past(wdata_i)} & MASK));

  p_hi_keeps_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> rd_full_o[31:0] == $past(rd_full_o[31:0]));

  p_no_stray_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_full_o & ~MASK) == 64'h0);

  p_probe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe |=> idx_o == 32'(NUM_ENTRIES - 1));

  p_oor_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor |=> $stable(idx_o));

  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o < 32'(NUM_ENTRIES));

  p_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_o == {{32{rd_full_o[31]}}, rd_full_o[31:0]});

  p_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_o == rd_full_o[63:32]);

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo_i, wr_hi_i, wr_idx_i}));

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo_i || wr_hi_i || wr_idx_i) |=> $stable(rd_full_o) && $stable(idx_o));
endmodule

bind attr_bank attr_bank_chk #(.NUM_ENTRIES(NUM_ENTRIES), .PA_WIDTH(PA_WIDTH)) u_chk (.*);

// File: tb/attr_bank_test.sv
`timescale 1ns/1ps
module attr_bank_test;
  localparam int NUM = 16;
  localparam logic [63:0] MASK = 64'h8000_0000_FFFF_F003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0, wr_idx = 1'b0;
  logic [31:0] wdata = '0;
  logic [63:0] rd_lo, rd_full;
  logic [31:0] rd_hi, idx;

  int errors = 0;
  int checks = 0;

  logic [63:0] mdl [NUM];
  int          mdl_idx = 0;

  always #2.5 clk = ~clk;

  attr_bank #(.NUM_ENTRIES(NUM), .PA_WIDTH(36)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_idx_i(wr_idx),
    .wdata_i(wdata), .rd_lo_o(rd_lo), .rd_hi_o(rd_hi), .rd_full_o(rd_full), .idx_o(idx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    logic [63:0] e;
    e = mdl[mdl_idx];
    chk({req, " full"}, rd_full, e);
    chk({req, " lo"}, rd_lo, {{32{e[31]}}, e[31:0]});
    chk({req, " hi"}, 64'(rd_hi), 64'(e[63:32]));
    chk({req, " idx"}, 64'(idx), 64'(mdl_idx));
  endtask

  // one strobe for one cycle, driven and released at falling edges
  task automatic do_wr(input int kind, input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    wr_lo = (kind == 0); wr_hi = (kind == 1); wr_idx = (kind == 2);
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0; wr_idx = 1'b0;
    case (kind)
      0: mdl[mdl_idx] = {32'h0, d} & MASK;
      1: mdl[mdl_idx] = {d & MASK[63:32], mdl[mdl_idx][31:0]};
      default: begin
        if (d[5:0] == 6'h3F) mdl_idx = NUM - 1;
        else if (int'(d[5:0]) < NUM) mdl_idx = int'(d[5:0]);
      end
    endcase
  endtask

  task automatic t_reset();
    chk("R1 entry", rd_full, 64'h0);
    chk("R1 idx", 64'(idx), 64'h0);
    chk_all("R10 reset");
  endtask

  task automatic t_halves();
    do_wr(0, 32'hFFFF_FFFF);
    chk("R2 R4 lo write", rd_full, 64'h0000_0000_FFFF_F003);
    chk("R8 sign ext", rd_lo, 64'hFFFF_FFFF_FFFF_F003);
    do_wr(1, 32'hFFFF_FFFF);
    chk("R3 R4 hi write", rd_full, 64'h8000_0000_FFFF_F003);
    chk("R9 hi read", 64'(rd_hi), 64'h8000_0000);
    do_wr(0, 32'h1234_5678);
    chk("R2 clears bit63", rd_full, 64'h0000_0000_1234_5000);
    chk("R8 positive", rd_lo, 64'h0000_0000_1234_5000);
    do_wr(1, 32'h7FFF_FFFF);
    chk("R3 no valid", rd_full, 64'h0000_0000_1234_5000);
    do_wr(1, 32'h8000_0000);
    chk("R3 merge", rd_full, 64'h8000_0000_1234_5000);
    chk_all("R9 halves");
  endtask

  task automatic t_index();
    do_wr(2, 32'h0000_003F);
    chk("R5 probe", 64'(idx), 64'(NUM - 1));
    do_wr(2, 32'hFFFF_FFC5);
    chk("R6 high bits ignored", 64'(idx), 64'd5);
    do_wr(2, 32'd20);
    chk("R7 out of range", 64'(idx), 64'd5);
    do_wr(2, 32'd62);
    chk("R7 top of range", 64'(idx), 64'd5);
    do_wr(2, 32'd16);
    chk("R7 first beyond", 64'(idx), 64'd5);
    do_wr(2, 32'd15);
    chk("R6 last entry", 64'(idx), 64'd15);
    chk_all("R10 idx read");
  endtask

  task automatic t_independent();
    do_wr(2, 32'd5);
    do_wr(0, 32'hA5A5_A5A7);
    chk("R11 entry5", rd_full, 64'h0000_0000_A5A5_A003);
    do_wr(1, 32'hFFFF_0000);
    do_wr(2, 32'd0);
    chk("R11 entry0 kept", rd_full, 64'h8000_0000_1234_5000);
    do_wr(2, 32'd6);
    chk("R11 entry6 untouched", rd_full, 64'h0);
    do_wr(2, 32'd5);
    chk("R11 entry5 kept", rd_full, 64'h8000_0000_A5A5_A003);
    chk_all("R11 final");
  endtask

  task automatic t_rdw();
    // data write and read of the same entry in one cycle
    @(negedge clk);
    wdata = 32'h0000_2001; wr_lo = 1'b1;
    #1;
    chk("R12 old before edge", rd_full, mdl[mdl_idx]);
    @(negedge clk);
    wr_lo = 1'b0;
    mdl[mdl_idx] = 64'h0000_0000_0000_2001;
    chk("R12 new after edge", rd_full, 64'h0000_0000_0000_2001);
    // index move and read in one cycle
    @(negedge clk);
    wdata = 32'd0; wr_idx = 1'b1;
    #1;
    chk("R12 idx old", 64'(idx), 64'd5);
    chk("R12 entry old", rd_full, 64'h0000_0000_0000_2001);
    @(negedge clk);
    wr_idx = 1'b0;
    mdl_idx = 0;
    chk_all("R12 moved");
  endtask

  initial begin
    for (int i = 0; i < NUM; i++) mdl[i] = '0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halves();
    t_index();
    t_independent();
    t_rdw();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule